// File: doc/BRIEF.md
# Transmit Start Gate and Frame Serializer

This block turns a transmit request into a serial frame on the wire. After a one-cycle transmit command it waits, holding its busy flag, until the interframe-gap timer, the backoff timer and the payload FIFO all permit a start. It then sends one bit per clock: a 64-bit lead-in (62 alternating bits and a closing `11` pair), the payload bytes pulled from the FIFO, and a 32-bit frame check sequence. If carrier appears while the FIFO is still empty, the block drops the request and signals a handoff to the receive path.

The payload arrives on a valid/ready byte stream. The source raises `fifo_valid` whenever it holds a byte and keeps `fifo_data` stable until it is taken. `fifo_ready` never depends on `fifo_valid`. A byte moves on a clock edge where both are high. The serializer cannot pause the line, so back-pressure runs one way only. The block asks for exactly one byte, and only in the cycle where the previous byte's last bit is on the line. A source that cannot supply it then causes an underrun that ends the frame.

Top module: `tx_launch_framer`

## Requirements
- R1: A `tx_go` pulse while `tx_busy` is low sets `tx_busy` from the next cycle on. A `tx_go` pulse while `tx_busy` is high has no effect: no second frame follows the current one.
- R2: `fetch_req` is high while a start is pending and `crs` is low, and during the whole frame. It is low while a start is pending and `crs` is high.
- R3: A pending start launches on a clock edge only when `ifg_ok`, `backoff_ok` and `fifo_valid` are all high. `tx_en` rises in the cycle after that edge.
- R4: While a start is pending, a cycle with `crs` high and `fifo_valid` low abandons it. In the next cycle `rx_handoff` pulses for one cycle and `tx_busy` is low, and `tx_en` never rises. If `fifo_valid` is high in that same cycle and the gates are open, the launch wins.
- R5: The first 64 bits sent while `tx_en` is high are 1,0,1,0,… for 62 bits, followed by 1,1.
- R6: The payload is exactly `byte_count` bytes, with the count latched at launch. Each byte is sent least significant bit first. A count of zero sends no payload and takes no byte.
- R7: `fifo_ready` is high only in the cycle that carries the last bit of the lead-in or of a payload byte that is followed by another payload byte.
- R8: The 32 check bits are the complement of a reflected CRC-32 (polynomial 0xEDB88320, preset all ones), computed over the payload bits in the order they are sent. Bit 0 of the complemented value is sent first.
- R9: In the cycle after the last check bit, `tx_done` pulses for one cycle and `tx_en` and `tx_busy` are low.
- R10: If `fifo_ready` is high and `fifo_valid` is low, then in the next cycle `tx_en` is low, `underrun` pulses for one cycle, `tx_busy` is low and `tx_done` stays low.
- R11: `crs` has no effect once a frame has launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_go | input | 1 | Transmit command pulse |
| byte_count | input | CNT_W | Payload length in bytes, sampled at launch |
| fifo_data | input | 8 | Payload byte from FIFO |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_ready | output | 1 | Block takes the byte this cycle |
| ifg_ok | input | 1 | Initial part of interframe gap has elapsed |
| backoff_ok | input | 1 | Backoff timer has expired |
| crs | input | 1 | Carrier sense |
| fetch_req | output | 1 | Permission to prefetch payload |
| tx_busy | output | 1 | Transmit command in force (self-clearing) |
| tx_en | output | 1 | Line bit valid |
| tx_bit | output | 1 | Serial line bit |
| tx_done | output | 1 | Frame completed pulse |
| rx_handoff | output | 1 | Start abandoned to receive pulse |
| underrun | output | 1 | Frame cut for lack of payload pulse |

## Verification
The abandon path and the launch path both act on a pending start in the same cycle when carrier and the first FIFO byte arrive together. The bench raises `crs` and `fifo_valid` on the same edge with both timers open. It expects a launch with no handoff pulse, and then a complete, correct frame while `crs` stays high. In the contrasting case the FIFO stays empty when carrier rises, and the bench expects the handoff pulse with no frame.

// File: rtl/tx_frm_pkg.sv
package tx_frm_pkg;
  localparam int BYTE_W    = 8;
  localparam int LEAD_B    = 8;
  localparam int FCS_W     = 32;
  localparam logic [BYTE_W-1:0] LEAD_BYTE  = 8'h55;
  localparam logic [BYTE_W-1:0] DELIM_BYTE = 8'hD5;
  localparam logic [FCS_W-1:0]  FCS_POLY   = 32'hEDB88320;

  typedef enum logic [1:0] {GS_IDLE, GS_WAIT, GS_RUN} gate_st_e;
  typedef enum logic [1:0] {PH_OFF, PH_LEAD, PH_DATA, PH_FCS} phase_e;

  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c, input logic d);
    logic [FCS_W-1:0] n;
    n = {1'b0, c[FCS_W-1:1]};
    if (c[0] ^ d) n = n ^ FCS_POLY;
    return n;
  endfunction
endpackage

// File: rtl/tx_start_gate.sv
module tx_start_gate
  import tx_frm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_go,
  input  logic ifg_ok,
  input  logic backoff_ok,
  input  logic fifo_valid,
  input  logic crs,
  input  logic frame_end,
  output logic launch,
  output logic tx_busy,
  output logic fetch_req,
  output logic rx_handoff
);
  gate_st_e st;
  logic     give_up;

  always_comb begin
    launch    = (st == GS_WAIT) && ifg_ok && backoff_ok && fifo_valid;
    give_up   = (st == GS_WAIT) && crs && !fifo_valid;
    tx_busy   = (st != GS_IDLE);
    fetch_req = ((st == GS_WAIT) && !crs) || (st == GS_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= GS_IDLE;
      rx_handoff <= 1'b0;
    end else begin
      rx_handoff <= give_up;
      unique case (st)
        GS_IDLE: if (tx_go) st <= GS_WAIT;
        GS_WAIT: begin
          if (launch)       st <= GS_RUN;
          else if (give_up) st <= GS_IDLE;
        end
        GS_RUN:  if (frame_end) st <= GS_IDLE;
        default: st <= GS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_fcs_gen.sv
module tx_fcs_gen
  import tx_frm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic absorb,
  input  logic drain,
  input  logic din,
  output logic fcs_bit
);
  logic [FCS_W-1:0] acc;

  assign fcs_bit = ~acc[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '1;
    else if (preset) acc <= '1;
    else if (absorb) acc <= fcs_step(acc, din);
    else if (drain)  acc <= {1'b1, acc[FCS_W-1:1]};
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import tx_frm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_valid,
  input  logic              fcs_bit,
  output logic              fifo_ready,
  output logic              tx_en,
  output logic              tx_bit,
  output logic              fcs_preset,
  output logic              fcs_absorb,
  output logic              fcs_drain,
  output logic              frame_end,
  output logic              tx_done,
  output logic              underrun
);
  localparam int BIT_CW  = $clog2(BYTE_W);
  localparam int LEAD_CW = $clog2(LEAD_B);
  localparam int FCS_CW  = $clog2(FCS_W);
  localparam logic [BIT_CW-1:0]  BIT_LAST  = BIT_CW'(BYTE_W - 1);
  localparam logic [LEAD_CW-1:0] LEAD_LAST = LEAD_CW'(LEAD_B - 1);
  localparam logic [LEAD_CW-1:0] LEAD_PEN  = LEAD_CW'(LEAD_B - 2);
  localparam logic [FCS_CW-1:0]  FCS_LAST  = FCS_CW'(FCS_W - 1);
  localparam logic [CNT_W-1:0]   ONE       = CNT_W'(1);

  phase_e              phase;
  logic [BYTE_W-1:0]   sreg;
  logic [BIT_CW-1:0]   bit_cnt;
  logic [LEAD_CW-1:0]  lead_idx;
  logic [CNT_W-1:0]    remaining;
  logic [FCS_CW-1:0]   fcs_cnt;
  logic                last_bit, need_byte, starve, fcs_last;

  always_comb begin
    last_bit  = (bit_cnt == BIT_LAST);
    need_byte = last_bit &&
                (((phase == PH_LEAD) && (lead_idx == LEAD_LAST) && (remaining != '0)) ||
                 ((phase == PH_DATA) && (remaining != ONE)));
    starve    = need_byte && !fifo_valid;
    fcs_last  = (phase == PH_FCS) && (fcs_cnt == FCS_LAST);
    frame_end = starve || fcs_last;
    fifo_ready = need_byte;
    tx_en      = (phase != PH_OFF);
    tx_bit     = (phase == PH_FCS) ? fcs_bit : ((phase == PH_OFF) ? 1'b0 : sreg[0]);
    fcs_preset = launch;
    fcs_absorb = (phase == PH_DATA);
    fcs_drain  = (phase == PH_FCS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_OFF;
      sreg      <= '0;
      bit_cnt   <= '0;
      lead_idx  <= '0;
      remaining <= '0;
      fcs_cnt   <= '0;
      tx_done   <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      tx_done  <= fcs_last;
      underrun <= starve;
      if (launch) begin
        phase     <= PH_LEAD;
        sreg      <= LEAD_BYTE;
        bit_cnt   <= '0;
        lead_idx  <= '0;
        remaining <= byte_count;
      end else begin
        unique case (phase)
          PH_LEAD: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (!last_bit) begin
              sreg <= sreg >> 1;
            end else if (lead_idx != LEAD_LAST) begin
              lead_idx <= lead_idx + 1'b1;
              sreg     <= (lead_idx == LEAD_PEN) ? DELIM_BYTE : LEAD_BYTE;
            end else if (remaining == '0) begin
              phase   <= PH_FCS;
              fcs_cnt <= '0;
            end else if (fifo_valid) begin
              phase <= PH_DATA;
              sreg  <= fifo_data;
            end else begin
              phase <= PH_OFF;
            end
          end
          PH_DATA: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (!last_bit) begin
              sreg <= sreg >> 1;
            end else if (remaining == ONE) begin
              phase   <= PH_FCS;
              fcs_cnt <= '0;
            end else if (fifo_valid) begin
              sreg      <= fifo_data;
              remaining <= remaining - 1'b1;
            end else begin
              phase <= PH_OFF;
            end
          end
          PH_FCS: begin
            fcs_cnt <= fcs_cnt + 1'b1;
            if (fcs_last) phase <= PH_OFF;
          end
          default: phase <= PH_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/tx_launch_framer.sv
module tx_launch_framer
  import tx_frm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_go,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  input  logic              ifg_ok,
  input  logic              backoff_ok,
  input  logic              crs,
  output logic              fetch_req,
  output logic              tx_busy,
  output logic              tx_en,
  output logic              tx_bit,
  output logic              tx_done,
  output logic              rx_handoff,
  output logic              underrun
);
  logic launch, frame_end, fcs_bit, fcs_preset, fcs_absorb, fcs_drain;

  tx_start_gate gate_i (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .ifg_ok(ifg_ok),
    .backoff_ok(backoff_ok), .fifo_valid(fifo_valid), .crs(crs),
    .frame_end(frame_end), .launch(launch), .tx_busy(tx_busy),
    .fetch_req(fetch_req), .rx_handoff(rx_handoff)
  );

  tx_serializer #(.CNT_W(CNT_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .byte_count(byte_count),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fcs_bit(fcs_bit),
    .fifo_ready(fifo_ready), .tx_en(tx_en), .tx_bit(tx_bit),
    .fcs_preset(fcs_preset), .fcs_absorb(fcs_absorb), .fcs_drain(fcs_drain),
    .frame_end(frame_end), .tx_done(tx_done), .underrun(underrun)
  );

  tx_fcs_gen fcs_i (
    .clk(clk), .rst_n(rst_n), .preset(fcs_preset), .absorb(fcs_absorb),
    .drain(fcs_drain), .din(tx_bit), .fcs_bit(fcs_bit)
  );
endmodule

// File: rtl/tx_launch_framer_chk.sv
module tx_launch_framer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_go,
  input logic [CNT_W-1:0] byte_count,
  input logic [7:0]       fifo_data,
  input logic             fifo_valid,
  input logic             fifo_ready,
  input logic             ifg_ok,
  input logic             backoff_ok,
  input logic             crs,
  input logic             fetch_req,
  input logic             tx_busy,
  input logic             tx_en,
  input logic             tx_bit,
  input logic             tx_done,
  input logic             rx_handoff,
  input logic             underrun
);
  // R1
  en_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> tx_busy);

  // R2
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !tx_en) |-> !crs);

  // R3
  launch_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(ifg_ok && backoff_ok && fifo_valid && tx_busy));

  // R4
  handoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_handoff |-> ($past(crs) && !$past(fifo_valid) && !tx_busy && !tx_en));

  // R5
  lead_first_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> tx_bit);

  // R7
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> tx_en);

  // R9
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> ($past(tx_en) && !tx_en && !tx_busy));

  // R10
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, rx_handoff, underrun}));

  // R10
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ($past(fifo_ready && !fifo_valid) && !tx_en && !tx_busy));
endmodule

bind tx_launch_framer tx_launch_framer_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/tx_launch_framer_tb_top.sv
module tx_launch_framer_tb_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_go = 0, ifg_ok = 0, backoff_ok = 0, crs = 0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [7:0] fifo_data;
  logic fifo_valid, fifo_ready, fetch_req, tx_busy, tx_en, tx_bit;
  logic tx_done, rx_handoff, underrun;

  logic [7:0] fmem [0:15];
  int fifo_n = 0, fifo_rd = 0;
  assign fifo_valid = (fifo_rd < fifo_n);
  assign fifo_data  = fmem[fifo_rd[3:0]];

  always #(CLK_P/2) clk = ~clk;

  tx_launch_framer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .byte_count(byte_count),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .ifg_ok(ifg_ok), .backoff_ok(backoff_ok), .crs(crs), .fetch_req(fetch_req),
    .tx_busy(tx_busy), .tx_en(tx_en), .tx_bit(tx_bit), .tx_done(tx_done),
    .rx_handoff(rx_handoff), .underrun(underrun)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  always @(posedge clk) if (fifo_valid && fifo_ready) fifo_rd <= fifo_rd + 1;

  logic cap [0:2047];
  int cap_n = 0, rdy_n = 0, done_n = 0, hand_n = 0, und_n = 0;
  int rdy_pos [0:31];
  always @(negedge clk) begin
    if (fifo_ready && rdy_n < 32) begin rdy_pos[rdy_n] = cap_n; rdy_n++; end
    if (tx_en && cap_n < 2048) begin cap[cap_n] = tx_bit; cap_n++; end
    if (tx_done) done_n++;
    if (rx_handoff) hand_n++;
    if (underrun) und_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_mon();
    cap_n = 0; rdy_n = 0; done_n = 0; hand_n = 0; und_n = 0;
  endtask

  task automatic pulse_go();
    tx_go = 1; @(negedge clk); tx_go = 0;
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit && done_n == 0 && und_n == 0; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
    logic [31:0] n;
    n = c >> 1;
    if (c[0] != d) n = n ^ 32'hEDB88320;
    return n;
  endfunction

  // Compare captured frame against lead-in, payload of n bytes, and check bits
  task automatic judge_frame(input int n, input string tag);
    logic [31:0] c = '1;
    int bad_lead = 0, bad_pay = 0, bad_fcs = 0, bad_rdy = 0;
    chk(cap_n == 64 + 8*n + 32, {tag, " R6 frame length"}, cap_n, 64 + 8*n + 32);
    if (cap_n == 64 + 8*n + 32) begin
      for (int i = 0; i < 64; i++)
        if (cap[i] != ((i == 63) ? 1'b1 : ((i % 2) == 0))) bad_lead++;
      for (int b = 0; b < n; b++)
        for (int k = 0; k < 8; k++) begin
          if (cap[64 + 8*b + k] != fmem[b][k]) bad_pay++;
          c = crc_bit(c, fmem[b][k]);
        end
      for (int k = 0; k < 32; k++)
        if (cap[64 + 8*n + k] != ~c[k]) bad_fcs++;
      chk(bad_lead == 0, {tag, " R5 lead-in bits"}, bad_lead, 0);
      chk(bad_pay == 0, {tag, " R6 payload bits"}, bad_pay, 0);
      chk(bad_fcs == 0, {tag, " R8 check bits"}, bad_fcs, 0);
    end
    chk(rdy_n == n, {tag, " R7 ready count"}, rdy_n, n);
    for (int b = 0; b < n && b < rdy_n; b++)
      if (rdy_pos[b] != 63 + 8*b) bad_rdy++;
    chk(bad_rdy == 0, {tag, " R7 ready position"}, bad_rdy, 0);
    chk(done_n == 1 && !tx_busy && !tx_en, {tag, " R9 done and clear"}, done_n, 1);
  endtask

  task automatic load(input int n, input int seed);
    for (int i = 0; i < 16; i++) fmem[i] = 8'((i * 37 + seed * 11 + 3) ^ (seed << 4));
    fifo_rd = 0; fifo_n = n;
  endtask

  task automatic t_reset();
    chk(!tx_en && !tx_busy && !fifo_ready && !fetch_req && !tx_done,
        "R1 reset idle", {tx_en, tx_busy, fifo_ready, fetch_req}, 0);
  endtask

  task automatic t_frame(input int n, input int seed);
    clear_mon(); load(n, seed); byte_count = CNT_W'(n);
    ifg_ok = 1; backoff_ok = 1;
    pulse_go();
    chk(tx_busy, "R1 busy after go", tx_busy, 1);
    wait_end(2000); cycles(1);
    judge_frame(n, "frame");
  endtask

  task automatic t_gates();
    clear_mon(); load(2, 5); byte_count = 2;
    ifg_ok = 0; backoff_ok = 1;
    pulse_go(); cycles(4);
    chk(tx_busy && !tx_en && fetch_req, "R3 held by gap timer", tx_en, 0);
    crs = 1; #1;
    chk(!fetch_req, "R2 fetch off under carrier", fetch_req, 0);
    @(negedge clk); crs = 0; #1;
    chk(fetch_req && hand_n == 0, "R2 fetch back on", fetch_req, 1);
    @(negedge clk);
    ifg_ok = 1; backoff_ok = 0; cycles(4);
    chk(!tx_en && cap_n == 0, "R3 held by backoff", cap_n, 0);
    backoff_ok = 1; @(negedge clk);
    chk(tx_en, "R3 launch one cycle after gates open", tx_en, 1);
    wait_end(2000); cycles(1);
    judge_frame(2, "gated");
  endtask

  task automatic t_abandon();
    clear_mon(); load(0, 1); byte_count = 3;
    ifg_ok = 1; backoff_ok = 1;
    pulse_go(); cycles(2);
    crs = 1; @(negedge clk);
    chk(rx_handoff && !tx_busy, "R4 handoff pulse", rx_handoff, 1);
    @(negedge clk);
    chk(!rx_handoff && hand_n == 1, "R4 single pulse", hand_n, 1);
    crs = 0; cycles(5);
    chk(cap_n == 0 && !tx_busy, "R4 no frame after abandon", cap_n, 0);
  endtask

  task automatic t_same_cycle();
    clear_mon(); load(0, 9); byte_count = 1;
    ifg_ok = 1; backoff_ok = 1;
    pulse_go(); cycles(2);
    crs = 1; fifo_n = 1; @(negedge clk);
    chk(tx_en && rx_handoff == 0, "R4 launch wins over abandon", tx_en, 1);
    // R11: carrier held high for the whole frame
    wait_end(2000); cycles(1);
    crs = 0;
    chk(hand_n == 0, "R11 carrier ignored in frame", hand_n, 0);
    judge_frame(1, "carrier");
  endtask

  task automatic t_go_while_busy();
    clear_mon(); load(1, 2); byte_count = 1;
    pulse_go(); cycles(20);
    pulse_go(); cycles(3); pulse_go();
    wait_end(2000); cycles(1);
    judge_frame(1, "R1 go during frame");
    clear_mon(); load(1, 2); cycles(100);
    chk(cap_n == 0 && !tx_busy, "R1 extra go ignored", cap_n, 0);
    fifo_n = 0;
  endtask

  task automatic t_underrun();
    clear_mon(); load(2, 4); byte_count = 4;
    pulse_go();
    wait_end(2000);
    chk(und_n == 1 && !tx_en && !tx_busy, "R10 underrun ends frame", und_n, 1);
    chk(cap_n == 64 + 16, "R10 bits before cut", cap_n, 80);
    cycles(2);
    chk(done_n == 0, "R10 no done on underrun", done_n, 0);
  endtask

  task automatic t_zero();
    clear_mon(); load(1, 6); byte_count = 0;
    pulse_go();
    wait_end(2000); cycles(1);
    judge_frame(0, "zero count");
    chk(fifo_rd == 0, "R6 zero count takes no byte", fifo_rd, 0);
    fifo_n = 0;
  endtask

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1; cycles(2);
    t_reset();
    t_frame(3, 1);   cycles(5);
    t_frame(6, 7);   cycles(5);
    t_frame(1, 3);   cycles(5);
    t_gates();       cycles(5);
    t_abandon();     cycles(5);
    t_same_cycle();  cycles(5);
    t_go_while_busy(); cycles(5);
    t_underrun();    cycles(5);
    t_zero();        cycles(5);
    finish_run();
  end
endmodule